// File: doc/BRIEF.md
# Dual Condition-Flag Compare Unit

This unit serves the flow-control side of a vector shading pipeline. On a compare instruction it takes the first two lanes (x and y) of two swizzled source vectors, in a 24-bit floating-point format. It tests each lane with its own relational operator and stores the two outcomes in a pair of persistent condition flags. The x outcome goes to flag 0 and the y outcome goes to flag 1. The z and w lanes do not take part.

The sequencer asks the unit whether a conditional branch is taken. Each stored flag is tested for equality against a reference bit from the branch instruction, which gives a match for x and a match for y. A two-bit combine mode then reduces the two matches to one condition-true output.

A program-start pulse clears both flags at the beginning of every vertex program. The flags change only on a clock edge with the compare strobe high. At all other times they keep their value.

Top module: `dual_cc_compare`

## Requirements
- R1: A synchronous reset or a program-start pulse clears both flags to 0 on the next clock edge. Program-start wins over a compare strobe in the same cycle.
- R2: An operand is sign in bit 23, a 7-bit exponent in bits 22:16 and a 16-bit mantissa in bits 15:0. Ordering is sign-magnitude, and any two operands with bits 22:0 all zero are equal, so +0 equals -0.
- R3: Compare-op encoding: 0 equal, 1 not-equal, 2 less-than, 3 less-or-equal, 4 greater-than, 5 greater-or-equal, always as first operand against second.
- R4: With the strobe high, flag_x takes the result of src1_x against src2_x under op_x on the next clock edge.
- R5: With the strobe high, flag_y takes the result of src1_y against src2_y under op_y in the same edge, and it is independent of op_x.
- R6: Negative operands order below positive ones, and a larger magnitude with a negative sign orders lower.
- R7: With the strobe low and no program start, both flags hold their value.
- R8: Compare-op codes 6 and 7 leave that lane's flag unchanged even when the strobe is high.
- R9: Match-x is (flag_x == ref_x) and match-y is (flag_y == ref_y). Combine encoding: 0 gives match-x OR match-y, 1 gives AND, 2 gives match-x only, 3 gives match-y only.
- R10: cond_true is combinational from the current flags, reference bits and combine mode, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_start | input | 1 | Start of a vertex program; clears the flags |
| cmp_en | input | 1 | Compare strobe; flags load on this edge |
| src1_x | input | 24 | First operand, x lane |
| src1_y | input | 24 | First operand, y lane |
| src2_x | input | 24 | Second operand, x lane |
| src2_y | input | 24 | Second operand, y lane |
| op_x | input | 3 | Relational operator for the x lane |
| op_y | input | 3 | Relational operator for the y lane |
| ref_x | input | 1 | Reference bit matched against flag_x |
| ref_y | input | 1 | Reference bit matched against flag_y |
| comb_mode | input | 2 | Reduction of the two matches |
| flag_x | output | 1 | Condition flag 0 |
| flag_y | output | 1 | Condition flag 1 |
| cond_true | output | 1 | Branch condition |

## Verification
The flags are due one clock edge after the strobe or program-start cycle. The bench drives inputs on the falling edge and reads the flags one time unit after the next rising edge, which catches an extra pipeline stage or a missing one. cond_true has no register, so the bench changes reference bits and mode on the falling edge and reads the output one time unit later, without any clock edge in between. The hold and invalid-op checks read the flags over several edges with operands chosen so that a wrong update would change them.

// File: rtl/dual_cc_compare_pkg.sv
package dual_cc_compare_pkg;

    localparam int FP_W     = 24;
    localparam int FP_EXP_W = 7;
    localparam int FP_MAN_W = 16;
    localparam int FP_MAG_W = FP_EXP_W + FP_MAN_W;
    localparam int OP_W     = 3;
    localparam int LANES    = 2;

    typedef logic [FP_W-1:0] fp_t;

    typedef enum logic [OP_W-1:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_LT = 3'd2,
        REL_LE = 3'd3,
        REL_GT = 3'd4,
        REL_GE = 3'd5
    } rel_op_e;

    typedef enum logic [1:0] {
        CMB_ANY  = 2'd0,
        CMB_ALL  = 2'd1,
        CMB_XSEL = 2'd2,
        CMB_YSEL = 2'd3
    } comb_e;

    typedef struct packed {
        logic below;
        logic same;
    } order_t;

    typedef struct packed {
        logic load;
        logic value;
    } lane_res_t;

    function automatic order_t fp_order(input fp_t a, input fp_t b);
        order_t o;
        logic [FP_MAG_W-1:0] ma, mb;
        ma = a[FP_MAG_W-1:0];
        mb = b[FP_MAG_W-1:0];
        if (ma == '0 && mb == '0) begin
            o.below = 1'b0;
            o.same  = 1'b1;
        end else if (a[FP_W-1] != b[FP_W-1]) begin
            o.below = a[FP_W-1];
            o.same  = 1'b0;
        end else if (!a[FP_W-1]) begin
            o.below = (ma < mb);
            o.same  = (ma == mb);
        end else begin
            o.below = (ma > mb);
            o.same  = (ma == mb);
        end
        return o;
    endfunction

endpackage

// File: rtl/dual_cc_compare_lane.sv
module dual_cc_compare_lane
    import dual_cc_compare_pkg::*;
(
    input  fp_t               lhs,
    input  fp_t               rhs,
    input  logic [OP_W-1:0]   op,
    output lane_res_t         res
);
    order_t ord;

    always_comb begin
        ord       = fp_order(lhs, rhs);
        res.load  = 1'b1;
        res.value = 1'b0;
        case (op)
            REL_EQ:  res.value = ord.same;
            REL_NE:  res.value = !ord.same;
            REL_LT:  res.value = ord.below;
            REL_LE:  res.value = ord.below | ord.same;
            REL_GT:  res.value = !(ord.below | ord.same);
            REL_GE:  res.value = !ord.below;
            default: res.load  = 1'b0;
        endcase
    end
endmodule

// File: rtl/dual_cc_compare_flags.sv
module dual_cc_compare_flags
    import dual_cc_compare_pkg::*;
#(
    parameter int N = LANES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_start,
    input  logic            cmp_en,
    input  lane_res_t       res [N],
    output logic [N-1:0]    flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || prog_start)
                flags[i] <= 1'b0;
            else if (cmp_en && res[i].load)
                flags[i] <= res[i].value;
        end
    end
endmodule

// File: rtl/dual_cc_compare_cond.sv
module dual_cc_compare_cond
    import dual_cc_compare_pkg::*;
(
    input  logic [1:0] flags,
    input  logic [1:0] refs,
    input  logic [1:0] mode,
    output logic       cond
);
    logic [1:0] hit;

    always_comb begin
        hit = ~(flags ^ refs);
        case (comb_e'(mode))
            CMB_ANY:  cond = hit[0] | hit[1];
            CMB_ALL:  cond = hit[0] & hit[1];
            CMB_XSEL: cond = hit[0];
            default:  cond = hit[1];
        endcase
    end
endmodule

// File: rtl/dual_cc_compare.sv
module dual_cc_compare
    import dual_cc_compare_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        prog_start,
    input  logic        cmp_en,
    input  logic [23:0] src1_x,
    input  logic [23:0] src1_y,
    input  logic [23:0] src2_x,
    input  logic [23:0] src2_y,
    input  logic [2:0]  op_x,
    input  logic [2:0]  op_y,
    input  logic        ref_x,
    input  logic        ref_y,
    input  logic [1:0]  comb_mode,
    output logic        flag_x,
    output logic        flag_y,
    output logic        cond_true
);
    fp_t             lhs [LANES];
    fp_t             rhs [LANES];
    logic [OP_W-1:0] ops [LANES];
    lane_res_t       res [LANES];
    logic [LANES-1:0] flags;

    assign lhs[0] = src1_x;
    assign lhs[1] = src1_y;
    assign rhs[0] = src2_x;
    assign rhs[1] = src2_y;
    assign ops[0] = op_x;
    assign ops[1] = op_y;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        dual_cc_compare_lane u_lane (
            .lhs (lhs[i]),
            .rhs (rhs[i]),
            .op  (ops[i]),
            .res (res[i])
        );
    end

    dual_cc_compare_flags #(.N(LANES)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .prog_start (prog_start),
        .cmp_en     (cmp_en),
        .res        (res),
        .flags      (flags)
    );

    dual_cc_compare_cond u_cond (
        .flags (flags),
        .refs  ({ref_y, ref_x}),
        .mode  (comb_mode),
        .cond  (cond_true)
    );

    assign flag_x = flags[0];
    assign flag_y = flags[1];
endmodule

// File: rtl/dual_cc_compare_chk.sv
module dual_cc_compare_chk (
    input logic        clk,
    input logic        rst,
    input logic        prog_start,
    input logic        cmp_en,
    input logic [23:0] src1_x,
    input logic [23:0] src2_x,
    input logic [2:0]  op_x,
    input logic [2:0]  op_y,
    input logic        ref_x,
    input logic        ref_y,
    input logic [1:0]  comb_mode,
    input logic        flag_x,
    input logic        flag_y,
    input logic        cond_true
);
    // R1
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> (!flag_x && !flag_y));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmp_en && !prog_start) |=> $stable({flag_x, flag_y}));

    // R8
    bad_op_x_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && !prog_start && op_x[2:1] == 2'b11) |=> $stable(flag_x));

    // R8
    bad_op_y_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && !prog_start && op_y[2:1] == 2'b11) |=> $stable(flag_y));

    // R2
    zero_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && !prog_start && op_x == 3'd0 &&
         src1_x[22:0] == 23'd0 && src2_x[22:0] == 23'd0) |=> flag_x);

    // R4
    self_ne_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && !prog_start && op_x == 3'd1 && src1_x == src2_x) |=> !flag_x);

    // R9
    all_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (comb_mode == 2'd1 && flag_x != ref_x) |-> !cond_true);

    // R9
    any_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (comb_mode == 2'd0 && flag_y == ref_y) |-> cond_true);
endmodule

bind dual_cc_compare dual_cc_compare_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .prog_start (prog_start),
    .cmp_en     (cmp_en),
    .src1_x     (src1_x),
    .src2_x     (src2_x),
    .op_x       (op_x),
    .op_y       (op_y),
    .ref_x      (ref_x),
    .ref_y      (ref_y),
    .comb_mode  (comb_mode),
    .flag_x     (flag_x),
    .flag_y     (flag_y),
    .cond_true  (cond_true)
);

// File: tb/dual_cc_compare_tb.sv
module dual_cc_compare_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, prog_start, cmp_en;
    logic [23:0] src1_x, src1_y, src2_x, src2_y;
    logic [2:0]  op_x, op_y;
    logic        ref_x, ref_y;
    logic [1:0]  comb_mode;
    logic        flag_x, flag_y, cond_true;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_cc_compare u_dut (
        .clk(clk), .rst(rst), .prog_start(prog_start), .cmp_en(cmp_en),
        .src1_x(src1_x), .src1_y(src1_y), .src2_x(src2_x), .src2_y(src2_y),
        .op_x(op_x), .op_y(op_y), .ref_x(ref_x), .ref_y(ref_y),
        .comb_mode(comb_mode), .flag_x(flag_x), .flag_y(flag_y),
        .cond_true(cond_true)
    );

    // 24-bit operands: sign, 7-bit exponent (bias 63), 16-bit mantissa
    localparam logic [23:0] P_ONE  = {1'b0, 7'd63, 16'h0000};
    localparam logic [23:0] P_1P5  = {1'b0, 7'd63, 16'h8000};
    localparam logic [23:0] P_TWO  = {1'b0, 7'd64, 16'h0000};
    localparam logic [23:0] N_ONE  = {1'b1, 7'd63, 16'h0000};
    localparam logic [23:0] N_TWO  = {1'b1, 7'd64, 16'h0000};
    localparam logic [23:0] P_ZERO = 24'h000000;
    localparam logic [23:0] N_ZERO = 24'h800000;

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // expected result of an operator from the ordering of a against b (R3)
    function automatic logic rel_expect(input int op, input logic lt, input logic eq);
        case (op)
            0: return eq;
            1: return !eq;
            2: return lt;
            3: return lt || eq;
            4: return !lt && !eq;
            default: return !lt;
        endcase
    endfunction

    task automatic strobe_once();
        @(negedge clk);
        cmp_en = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        cmp_en = 1'b0;
    endtask

    task automatic load_flags(input logic fx, input logic fy);
        @(negedge clk);
        src1_x = P_ONE; src2_x = P_ONE; src1_y = P_ONE; src2_y = P_ONE;
        op_x = fx ? 3'd0 : 3'd1;
        op_y = fy ? 3'd0 : 3'd1;
        cmp_en = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        cmp_en = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1; prog_start = 1'b0; cmp_en = 1'b0;
        src1_x = '0; src1_y = '0; src2_x = '0; src2_y = '0;
        op_x = '0; op_y = '0; ref_x = 1'b0; ref_y = 1'b0; comb_mode = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset flag_x", flag_x, 1'b0);
        chk("R1 reset flag_y", flag_y, 1'b0);
        chk("R10 reset cond", cond_true, 1'b1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // both lanes in one strobe, independent ops; y uses swapped operands
    task automatic test_pair(input string req, input logic [23:0] a, input logic [23:0] b,
                             input logic lt, input logic eq);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            src1_x = a; src2_x = b; op_x = 3'(k);
            src1_y = b; src2_y = a; op_y = 3'(5 - k);
            cmp_en = 1'b1;
            @(posedge clk); #1;
            chk({req, " R4 flag_x"}, flag_x, rel_expect(k, lt, eq));
            chk({req, " R5 flag_y"}, flag_y, rel_expect(5 - k, !lt && !eq, eq));
            @(negedge clk);
            cmp_en = 1'b0;
        end
    endtask

    task automatic test_hold();
        load_flags(1'b1, 1'b0);
        @(negedge clk);
        src1_x = P_ONE; src2_x = P_TWO; op_x = 3'd0;
        src1_y = P_ONE; src2_y = P_ONE; op_y = 3'd0;
        repeat (3) begin
            @(posedge clk); #1;
            chk("R7 hold flag_x", flag_x, 1'b1);
            chk("R7 hold flag_y", flag_y, 1'b0);
        end
    endtask

    task automatic test_bad_op();
        load_flags(1'b1, 1'b0);
        @(negedge clk);
        src1_x = P_ONE; src2_x = P_TWO; op_x = 3'd6;
        src1_y = P_ONE; src2_y = P_ONE; op_y = 3'd7;
        cmp_en = 1'b1;
        @(posedge clk); #1;
        chk("R8 op6 flag_x", flag_x, 1'b1);
        chk("R8 op7 flag_y", flag_y, 1'b0);
        @(negedge clk);
        op_x = 3'd7; op_y = 3'd6;
        @(posedge clk); #1;
        chk("R8 op7 flag_x", flag_x, 1'b1);
        chk("R8 op6 flag_y", flag_y, 1'b0);
        @(negedge clk);
        op_x = 3'd1; op_y = 3'd6;
        @(posedge clk); #1;
        chk("R8 mixed flag_x", flag_x, 1'b1);
        chk("R8 mixed flag_y", flag_y, 1'b0);
        @(negedge clk);
        cmp_en = 1'b0;
    endtask

    task automatic test_start();
        load_flags(1'b1, 1'b1);
        @(negedge clk);
        prog_start = 1'b1;
        @(posedge clk); #1;
        chk("R1 start flag_x", flag_x, 1'b0);
        chk("R1 start flag_y", flag_y, 1'b0);
        load_flags(1'b1, 1'b1);
        @(negedge clk);
        prog_start = 1'b1; cmp_en = 1'b1;
        src1_x = P_ONE; src2_x = P_ONE; op_x = 3'd0;
        src1_y = P_ONE; src2_y = P_ONE; op_y = 3'd0;
        @(posedge clk); #1;
        chk("R1 start beats strobe x", flag_x, 1'b0);
        chk("R1 start beats strobe y", flag_y, 1'b0);
        @(negedge clk);
        prog_start = 1'b0; cmp_en = 1'b0;
    endtask

    task automatic test_combine();
        for (int f = 0; f < 4; f++) begin
            load_flags(f[0], f[1]);
            for (int r = 0; r < 4; r++) begin
                for (int m = 0; m < 4; m++) begin
                    logic mx, my, e;
                    @(negedge clk);
                    ref_x = r[0]; ref_y = r[1]; comb_mode = 2'(m);
                    #1;
                    mx = (f[0] == r[0]);
                    my = (f[1] == r[1]);
                    case (m)
                        0: e = mx || my;
                        1: e = mx && my;
                        2: e = mx;
                        default: e = my;
                    endcase
                    chk("R9 R10 cond_true", cond_true, e);
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        test_reset();
        test_pair("R3 1<2",   P_ONE, P_TWO, 1'b1, 1'b0);
        test_pair("R3 2==2",  P_TWO, P_TWO, 1'b0, 1'b1);
        test_pair("R2 1.5>1", P_1P5, P_ONE, 1'b0, 1'b0);
        test_pair("R6 -2<-1", N_TWO, N_ONE, 1'b1, 1'b0);
        test_pair("R6 -1<1",  N_ONE, P_ONE, 1'b1, 1'b0);
        test_pair("R6 0>-1",  P_ZERO, N_ONE, 1'b0, 1'b0);
        test_pair("R2 +0==-0", P_ZERO, N_ZERO, 1'b0, 1'b1);
        test_hold();
        test_bad_op();
        test_start();
        test_combine();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule